// File: doc/BRIEF.md
# Encoded 32-bit ALU with zero flag

This block is the combinational arithmetic and logic unit of a simple single-cycle processor datapath. It takes two operands, `opa` and `opb`, and a four-bit operation selector, `op_sel`. It produces a result and a flag, `res_zero`, that is set when the result is all zeros. Nothing in the block is clocked, and it holds no state.

The operations are:

- addition and subtraction, with wrap-around;
- AND, OR and XOR;
- placement of an upper immediate;
- three shifts: logical left, logical right and arithmetic right.

For the shifts, the data is `opb` and the amount is the low five bits of `opa`. A branch that tests two registers for equality issues the XOR code and reads `res_zero`. Only the two right shifts decode selector bit 3. For every other code, that bit has no effect.

Top module: `alu_core`

## Requirements
- R1: `op_sel[2:0]=000` gives `res = opa + opb` modulo 2^32, with no overflow indication.
- R2: `op_sel[2:0]=100` gives `res = opa - opb` modulo 2^32.
- R3: `op_sel[2:0]=001` gives `opa & opb`, and `op_sel[2:0]=101` gives `opa | opb`.
- R4: `op_sel[2:0]=010` gives `opa ^ opb`, so `res_zero` is 1 exactly when `opa == opb`.
- R5: `op_sel[2:0]=110` gives `{opb[15:0], 16'h0000}`.
- R6: `op_sel[2:0]=011` gives `opb << opa[4:0]`. Bits `opa[31:5]` are ignored, and an amount of 0 returns `opb` unchanged.
- R7: `op_sel=4'b0111` gives `opb >> opa[4:0]` with zero fill. An amount of 0 returns `opb`.
- R8: `op_sel=4'b1111` gives an arithmetic right shift of `opb` by `opa[4:0]` that replicates `opb[31]`. An amount of 0 returns `opb`.
- R9: `res_zero` is 1 exactly when all 32 bits of `res` are 0, for every selector value.
- R10: For every `op_sel[2:0]` other than 111, `op_sel[3]` has no effect on `res` or `res_zero`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 32 | First operand; its low five bits give the shift amount |
| opb | input | 32 | Second operand; the shifted data and the upper-immediate source |
| op_sel | input | 4 | Operation selector |
| res | output | 32 | Result |
| res_zero | output | 1 | 1 when `res` is all zeros |

## Verification
The bound checker tests properties on every input change:

- the sum and the difference relations;
- XOR equality through the zero flag;
- the zero low half of the upper-immediate result;
- identity for a shift amount of 0;
- sign preservation in arithmetic right shifts.

Exact shift results at every amount, the don't-care role of selector bit 3, and the zero flag across all codes can only be shown by the bench's sweeps. These sweeps cover all sixteen selector values over corner operands and a pseudo-random stream. The bench compares each result against arithmetic it computes itself.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned DATA_W = 32;

  // Low three selector bits; bit 3 refines only the right-shift code.
  typedef enum logic [2:0] {
    SEL_ADD  = 3'b000,
    SEL_AND  = 3'b001,
    SEL_XOR  = 3'b010,
    SEL_SHL  = 3'b011,
    SEL_SUB  = 3'b100,
    SEL_OR   = 3'b101,
    SEL_UPIM = 3'b110,
    SEL_SHR  = 3'b111
  } alu_sel_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         subtract,
  output logic [W-1:0] sum
);
  logic [W-1:0] y_eff;

  always_comb begin
    y_eff = y ^ {W{subtract}};
    sum   = x + y_eff + {{(W-1){1'b0}}, subtract};
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [1:0]   fn,
  output logic [W-1:0] out
);
  // fn: 00 and, 01 or, 10 xor, 11 upper-immediate placement of y
  localparam int unsigned HALF = W / 2;

  always_comb begin
    unique case (fn)
      2'b00:   out = x & y;
      2'b01:   out = x | y;
      2'b10:   out = x ^ y;
      default: out = {y[HALF-1:0], {HALF{1'b0}}};
    endcase
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  d,
  input  logic [SW-1:0] amt,
  input  logic          left,
  input  logic          arith,
  output logic [W-1:0]  y
);
  logic [W-1:0] d_rev;
  logic [W-1:0] stage [SW+1];
  logic [W-1:0] out_rev;
  logic         fill;

  // Bit reversal lets one right-shifting log stage chain serve left shifts.
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign d_rev[i]   = d[W-1-i];
    assign out_rev[i] = stage[SW][W-1-i];
  end

  assign fill     = arith & ~left & d[W-1];
  assign stage[0] = left ? d_rev : d;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int unsigned STEP = 1 << k;
    assign stage[k+1] = amt[k] ? {{STEP{fill}}, stage[k][W-1:STEP]} : stage[k];
  end

  assign y = left ? out_rev : stage[SW];
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [3:0]   op_sel,
  output logic [W-1:0] res,
  output logic         res_zero
);
  localparam int unsigned SW = $clog2(W);

  alu_sel_e     sel;
  logic [W-1:0] arith_out;
  logic [W-1:0] logic_out;
  logic [W-1:0] shift_out;
  logic [1:0]   logic_fn;
  logic         is_left;

  assign sel = alu_sel_e'(op_sel[2:0]);

  always_comb begin
    unique case (sel)
      SEL_AND: logic_fn = 2'b00;
      SEL_OR:  logic_fn = 2'b01;
      SEL_XOR: logic_fn = 2'b10;
      default: logic_fn = 2'b11;
    endcase
  end

  assign is_left = (sel == SEL_SHL);

  alu_addsub #(.W(W)) u_addsub (
    .x(opa), .y(opb), .subtract(op_sel[2]), .sum(arith_out)
  );

  alu_logic #(.W(W)) u_logic (
    .x(opa), .y(opb), .fn(logic_fn), .out(logic_out)
  );

  alu_shift #(.W(W), .SW(SW)) u_shift (
    .d(opb), .amt(opa[SW-1:0]), .left(is_left), .arith(op_sel[3]),
    .y(shift_out)
  );

  always_comb begin
    unique case (sel)
      SEL_ADD, SEL_SUB:                   res = arith_out;
      SEL_AND, SEL_OR, SEL_XOR, SEL_UPIM: res = logic_out;
      default:                            res = shift_out;
    endcase
  end

  assign res_zero = ~|res;
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
  parameter int unsigned W = 32
) (
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [3:0]   op_sel,
  input logic [W-1:0] res,
  input logic         res_zero
);
  localparam int unsigned HALF = W / 2;
  localparam int unsigned SW   = $clog2(W);

  logic known;
  assign known = !$isunknown({opa, opb, op_sel});

  always_comb begin
    if (known) begin
      if (op_sel[2:0] == 3'b000)
        a_r1_sum_wraps: assert (res - opb == opa);
      if (op_sel[2:0] == 3'b100)
        a_r2_diff_wraps: assert (res + opb == opa);
      if (op_sel[2:0] == 3'b010)
        a_r4_xor_equality: assert (res_zero == (opa == opb));
      if (op_sel[2:0] == 3'b110)
        a_r5_upper_low_clear: assert (res[HALF-1:0] == '0);
      if (op_sel[2:0] == 3'b011 && opa[SW-1:0] == '0)
        a_r6_shl_zero_amount: assert (res == opb);
      if (op_sel == 4'b0111 && opa[SW-1:0] == '0)
        a_r7_shr_zero_amount: assert (res == opb);
      if (op_sel == 4'b1111)
        a_r8_sra_sign_kept: assert (res[W-1] == opb[W-1]);
      if (op_sel == 4'b0111 && opa[SW-1:0] != '0)
        a_r7_shr_top_clear: assert (res[W-1] == 1'b0);
    end
  end
endmodule

bind alu_core alu_core_chk #(.W(W)) u_chk (
  .opa(opa), .opb(opb), .op_sel(op_sel), .res(res), .res_zero(res_zero)
);

// File: tb/sim_alu_core.sv
module sim_alu_core;
  logic        clk = 1'b0;
  logic [31:0] opa, opb;
  logic [3:0]  op_sel;
  logic [31:0] res;
  logic        res_zero;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  alu_core u0 (.opa(opa), .opb(opb), .op_sel(op_sel), .res(res), .res_zero(res_zero));

  function automatic logic [31:0] ref_res(input logic [31:0] a, input logic [31:0] b,
                                           input logic [3:0] s);
    int sh = int'(a[4:0]);
    case (s[2:0])
      3'b000: return a + b;
      3'b100: return a - b;
      3'b001: return a & b;
      3'b101: return a | b;
      3'b010: return a ^ b;
      3'b110: return b * 32'd65536;
      3'b011: return b * (32'd1 << sh);
      default: begin
        logic [31:0] r = b / (32'd1 << sh);
        if (s[3] && b[31] && sh != 0) r = r | ~(32'hFFFF_FFFF >> sh);
        return r;
      end
    endcase
  endfunction

  function automatic string tag(input logic [3:0] s);
    case (s[2:0])
      3'b000: return "R1";
      3'b100: return "R2";
      3'b001, 3'b101: return "R3";
      3'b010: return "R4";
      3'b110: return "R5";
      3'b011: return "R6";
      default: return s[3] ? "R8" : "R7";
    endcase
  endfunction

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [3:0] s);
    logic [31:0] e;
    @(negedge clk);
    opa = a; opb = b; op_sel = s;
    #1;
    e = ref_res(a, b, s);
    checks++;
    if (res !== e) begin
      errors++;
      $display("FAIL %s op=%h a=%h b=%h res=%h expected=%h", tag(s), s, a, b, res, e);
    end
    checks++;
    if (res_zero !== (e == 32'd0)) begin
      errors++;
      $display("FAIL R9 op=%h a=%h b=%h zero=%b expected=%b", s, a, b, res_zero, e == 32'd0);
    end
  endtask

  // R10: the two codes differing in bit 3 must give identical outputs
  task automatic pair_check(input logic [31:0] a, input logic [31:0] b, input logic [2:0] lo);
    logic [31:0] r0;
    logic z0;
    @(negedge clk);
    opa = a; opb = b; op_sel = {1'b0, lo};
    #1; r0 = res; z0 = res_zero;
    op_sel = {1'b1, lo};
    #1;
    checks++;
    if (res !== r0 || res_zero !== z0) begin
      errors++;
      $display("FAIL R10 lo=%b a=%h b=%h res=%h/%b expected=%h/%b", lo, a, b, res, res_zero, r0, z0);
    end
  endtask

  logic [31:0] corners [10] = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF,
                                32'h1, 32'h10, 32'h1F, 32'hFFFF_FFE1,
                                32'h1234_5678, 32'hA5A5_0F0F};

  initial begin
    logic [31:0] lfsr_a = 32'hACE1_2345;
    logic [31:0] lfsr_b = 32'h1357_9BDF;
    opa = '0; opb = '0; op_sel = '0;
    #1;
    checks++;
    if (res !== 32'h0 || res_zero !== 1'b1) begin
      errors++;
      $display("FAIL R9 idle res=%h zero=%b expected=00000000/1", res, res_zero);
    end
    // R1..R9 corner sweep over all sixteen codes
    for (int s = 0; s < 16; s++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j++)
          apply(corners[i], corners[j], 4'(s));
    // R6 R7 R8: every amount, with junk above bit 4 of opa to show it is ignored
    for (int sh = 0; sh < 32; sh++) begin
      apply(32'hFFFF_FFE0 | 32'(sh), 32'h8000_0001, 4'b0011);
      apply(32'h0000_0100 | 32'(sh), 32'hF0F0_1234, 4'b0111);
      apply(32'(sh), 32'h8765_4321, 4'b1111);
      apply(32'(sh), 32'h4765_4321, 4'b1111);
    end
    // R4: equality through the zero flag
    apply(32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'b0010);
    apply(32'hDEAD_BEEF, 32'hDEAD_BEEE, 4'b1010);
    // R10 and pseudo-random stream
    for (int n = 0; n < 800; n++) begin
      lfsr_a = {lfsr_a[30:0], lfsr_a[31] ^ lfsr_a[21] ^ lfsr_a[1] ^ lfsr_a[0]};
      lfsr_b = {lfsr_b[30:0], lfsr_b[31] ^ lfsr_b[21] ^ lfsr_b[1] ^ lfsr_b[0]};
      apply(lfsr_a, lfsr_b, lfsr_a[3:0] ^ lfsr_b[7:4]);
      pair_check(lfsr_a, lfsr_b, 3'(n % 7));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule